// File: doc/BRIEF.md
# Interrupt Pending-Status Controller

This block keeps a 32-bit word of pending interrupt causes and drives one level-sensitive interrupt line from it. Software posts causes by writing a mask to a raise register; every bit set in the mask becomes pending. Software retires causes by writing a mask to an acknowledge register; every bit set in that mask is cleared. The pending word can be read back at a status offset. Two internal event pulses, one for completion of a computation and one for completion of a memory transfer, each set a fixed pending bit when their own enable is high.

The interrupt line is high whenever at least one cause is pending, so it stays asserted until the handler has acknowledged every cause. When a cause sets a bit in the same cycle an acknowledge clears it, the set wins, so an event arriving during acknowledgement is never lost. Register access is a simple single-cycle write strobe plus a read address whose data appears on the following clock.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pending word, `irq_o` and `rd_data` all become zero.
- R2: A write with `wr_addr` = 0x60 ORs `wr_data` into the pending word at that clock edge.
- R3: A write with `wr_addr` = 0x64 clears each pending bit whose position is 1 in `wr_data`, leaving the other bits as they were.
- R4: `rd_data` after a rising edge equals the pending word held just before that edge when `rd_addr` was 0x24 at the edge.
- R5: A write to any address other than 0x60 or 0x64, including the status offset 0x24, leaves the pending word unchanged.
- R6: `rd_data` after a rising edge is zero when `rd_addr` at that edge was anything other than 0x24, including the write-only offsets 0x60 and 0x64.
- R7: `irq_o` is high exactly when the pending word is nonzero; it stays high after a partial acknowledge and falls only after an acknowledge that clears the last pending bit.
- R8: A `calc_done_i` pulse with `calc_irq_en_i` high sets pending bit 0 (value 0x1); with the enable low it has no effect.
- R9: A `dma_done_i` pulse with `dma_irq_en_i` high sets pending bit 8 (value 0x100); with the enable low it has no effect.
- R10: When a bit is both set (by a raise write or an enabled event) and acknowledged in the same cycle, it ends up pending.
- R11: A raise write and both enabled events in one cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write mask |
| rd_addr | input | 8 | Byte offset to read; data follows one cycle later |
| rd_data | output | 32 | Registered read data |
| calc_done_i | input | 1 | Computation-finished event pulse |
| calc_irq_en_i | input | 1 | Lets `calc_done_i` post its cause |
| dma_done_i | input | 1 | Transfer-finished event pulse |
| dma_irq_en_i | input | 1 | Lets `dma_done_i` post its cause |
| irq_o | output | 1 | Level interrupt request, high while any cause is pending |

## Verification
The bench goes after an acknowledge that coincides with an enabled event on the same bit; a design that let the clear win would drop that event and lower the line with work still outstanding. It writes to the read-only status offset and to an unmapped offset, which a sloppy decoder would turn into a raise or an acknowledge, and reads the write-only offsets, which a mux that only checks a few address bits would answer with the pending word. Partial acknowledges check that the line does not fall early, disabled event pulses check that the enables gate, and a reset in the middle of activity checks that stale causes do not survive it.

// File: rtl/irq_pend_pkg.sv
// Package: shared defaults for the interrupt pending-status controller.
// Assumes byte offsets are decoded on the full address; nothing else shared.
package irq_pend_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned OFS_W       = 8;
    localparam logic [7:0]  OFS_STATUS  = 8'h24;
    localparam logic [7:0]  OFS_RAISE   = 8'h60;
    localparam logic [7:0]  OFS_ACK     = 8'h64;
    localparam int unsigned CALC_POS    = 0;
    localparam int unsigned DMA_POS     = 8;

    // Which register a write targets.
    typedef enum logic [1:0] {
        WSEL_NONE  = 2'd0,
        WSEL_RAISE = 2'd1,
        WSEL_ACK   = 2'd2
    } wsel_e;
endpackage

// File: rtl/irq_pend_wdec.sv
// Module: write decoder. Turns one write strobe into a software set mask
// and a software clear mask. Assumes at most one write per cycle, so the
// two masks are never nonzero together.
module irq_pend_wdec #(
    parameter int unsigned   DATA_W    = irq_pend_pkg::WORD_W,
    parameter int unsigned   ADDR_W    = irq_pend_pkg::OFS_W,
    parameter logic [ADDR_W-1:0] RAISE_OFS = ADDR_W'(irq_pend_pkg::OFS_RAISE),
    parameter logic [ADDR_W-1:0] ACK_OFS   = ADDR_W'(irq_pend_pkg::OFS_ACK)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sw_set,
    output logic [DATA_W-1:0] sw_clr
);
    import irq_pend_pkg::*;

    wsel_e sel;

    // Classify the write target; unmapped or read-only offsets select nothing.
    always_comb begin
        sel = WSEL_NONE;
        if (wr_en) begin
            if (wr_addr == RAISE_OFS)     sel = WSEL_RAISE;
            else if (wr_addr == ACK_OFS)  sel = WSEL_ACK;
        end
    end

    // Route the written mask to the set or the clear path.
    always_comb begin
        sw_set = (sel == WSEL_RAISE) ? wr_data : '0;
        sw_clr = (sel == WSEL_ACK)   ? wr_data : '0;
    end
endmodule

// File: rtl/irq_pend_hwsrc.sv
// Module: hardware cause mapper. Each internal event, when its enable is
// high, contributes one fixed bit to a set mask. Assumes events are
// single-cycle pulses; a held pulse simply keeps setting its bit.
module irq_pend_hwsrc #(
    parameter int unsigned DATA_W  = irq_pend_pkg::WORD_W,
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned IDX_W   = $clog2(DATA_W),
    parameter logic [NUM_SRC-1:0][IDX_W-1:0] SRC_POS = '0
) (
    input  logic [NUM_SRC-1:0] ev_done,
    input  logic [NUM_SRC-1:0] ev_en,
    output logic [DATA_W-1:0]  hw_set
);
    logic [NUM_SRC-1:0][DATA_W-1:0] src_mask;

    // One gated one-hot mask per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_mask[s] = (ev_done[s] && ev_en[s])
                           ? (DATA_W'(1) << SRC_POS[s]) : '0;
    end

    // Merge all source masks.
    always_comb begin
        hw_set = '0;
        for (int s = 0; s < NUM_SRC; s++) hw_set = hw_set | src_mask[s];
    end
endmodule

// File: rtl/irq_pend_bits.sv
// Module: pending-bit store. One flop per cause; a set beats a clear in
// the same cycle. The level output is the OR of all pending bits.
// Assumes synchronous active-low reset.
module irq_pend_bits #(
    parameter int unsigned DATA_W = irq_pend_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] pend_q,
    output logic              any_pend
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic bit_q;

        // Hold one cause: set has priority so no event is dropped.
        always_ff @(posedge clk) begin
            if (!rst_n)            bit_q <= 1'b0;
            else if (set_mask[b])  bit_q <= 1'b1;
            else if (clr_mask[b])  bit_q <= 1'b0;
        end

        assign pend_q[b] = bit_q;
    end

    // Level request while anything is outstanding.
    assign any_pend = |pend_q;
endmodule

// File: rtl/irq_pend_rdport.sv
// Module: registered read port. Returns the pending word at the status
// offset and zero everywhere else, one cycle after the address.
module irq_pend_rdport #(
    parameter int unsigned   DATA_W     = irq_pend_pkg::WORD_W,
    parameter int unsigned   ADDR_W     = irq_pend_pkg::OFS_W,
    parameter logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(irq_pend_pkg::OFS_STATUS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] rd_data
);
    // Capture the addressed value; write-only and unmapped offsets read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_data <= '0;
        else if (rd_addr == STATUS_OFS) rd_data <= pend;
        else                          rd_data <= '0;
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: top of the interrupt pending-status controller. Combines the
// software set/clear masks and the hardware event masks into one pending
// store, and exposes a read port and a level interrupt line.
// Assumes a single write port and synchronous active-low reset.
module irq_pend_ctrl #(
    parameter int unsigned   DATA_W     = irq_pend_pkg::WORD_W,
    parameter int unsigned   ADDR_W     = irq_pend_pkg::OFS_W,
    parameter logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(irq_pend_pkg::OFS_STATUS),
    parameter logic [ADDR_W-1:0] RAISE_OFS  = ADDR_W'(irq_pend_pkg::OFS_RAISE),
    parameter logic [ADDR_W-1:0] ACK_OFS    = ADDR_W'(irq_pend_pkg::OFS_ACK),
    parameter int unsigned   CALC_BIT   = irq_pend_pkg::CALC_POS,
    parameter int unsigned   DMA_BIT    = irq_pend_pkg::DMA_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              calc_done_i,
    input  logic              calc_irq_en_i,
    input  logic              dma_done_i,
    input  logic              dma_irq_en_i,
    output logic              irq_o
);
    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned IDX_W   = $clog2(DATA_W);
    localparam logic [NUM_SRC-1:0][IDX_W-1:0] SRC_POS =
        {IDX_W'(DMA_BIT), IDX_W'(CALC_BIT)};

    logic [DATA_W-1:0] sw_set;
    logic [DATA_W-1:0] sw_clr;
    logic [DATA_W-1:0] hw_set;
    logic [DATA_W-1:0] set_all;
    logic [DATA_W-1:0] pend_q;

    irq_pend_wdec #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS)
    ) u_wdec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sw_set(sw_set), .sw_clr(sw_clr)
    );

    irq_pend_hwsrc #(
        .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SRC_POS(SRC_POS)
    ) u_hwsrc (
        .ev_done({dma_done_i, calc_done_i}),
        .ev_en({dma_irq_en_i, calc_irq_en_i}),
        .hw_set(hw_set)
    );

    // All set requests, software and hardware, share one priority path.
    assign set_all = sw_set | hw_set;

    irq_pend_bits #(.DATA_W(DATA_W)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .set_mask(set_all), .clr_mask(sw_clr),
        .pend_q(pend_q), .any_pend(irq_o)
    );

    irq_pend_rdport #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
        .pend(pend_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
// Module: property checker for irq_pend_ctrl, attached by bind below.
// Observes ports plus the pending store and the hardware set mask.
module irq_pend_ctrl_chk #(
    parameter int unsigned   DATA_W     = 32,
    parameter int unsigned   ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h24,
    parameter logic [ADDR_W-1:0] RAISE_OFS  = 8'h60,
    parameter logic [ADDR_W-1:0] ACK_OFS    = 8'h64,
    parameter int unsigned   CALC_BIT   = 0,
    parameter int unsigned   DMA_BIT    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              calc_done_i,
    input logic              calc_irq_en_i,
    input logic              dma_done_i,
    input logic              dma_irq_en_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] hw_set
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && rd_data == '0 && !irq_o));

    // R2
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_addr == RAISE_OFS))
        |-> ((pend_q & $past(wr_data)) == $past(wr_data)));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_addr == ACK_OFS) && $past(hw_set) == '0)
        |-> ((pend_q & $past(wr_data)) == '0));

    // R5
    other_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_addr != RAISE_OFS && wr_addr != ACK_OFS)
         && $past(hw_set) == '0)
        |-> $stable(pend_q));

    // R4
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_addr == STATUS_OFS))
        |-> (rd_data == $past(pend_q)));

    // R6
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_addr != STATUS_OFS)) |-> (rd_data == '0));

    // R7
    irq_falls_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(irq_o)) |-> $past(wr_en && wr_addr == ACK_OFS));

    // R8 R10
    calc_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && calc_done_i && calc_irq_en_i) |-> pend_q[CALC_BIT]);

    // R9 R10
    dma_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && dma_done_i && dma_irq_en_i) |-> pend_q[DMA_BIT]);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS),
    .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS),
    .CALC_BIT(CALC_BIT), .DMA_BIT(DMA_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .calc_done_i(calc_done_i), .calc_irq_en_i(calc_irq_en_i),
    .dma_done_i(dma_done_i), .dma_irq_en_i(dma_irq_en_i),
    .irq_o(irq_o), .pend_q(pend_q), .hw_set(hw_set)
);

// File: tb/irq_pend_ctrl_test.sv
// Bench: scoreboard. The driver steps one cycle at a time, updates a
// reference pending word from the requirements and queues expected
// rd_data and irq_o values; the monitor compares them on falling edges.
module irq_pend_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        calc_done_i = 1'b0, calc_irq_en_i = 1'b0;
    logic        dma_done_i = 1'b0, dma_irq_en_i = 1'b0;
    logic        irq_o;

    irq_pend_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .calc_done_i(calc_done_i), .calc_irq_en_i(calc_irq_en_i),
        .dma_done_i(dma_done_i), .dma_irq_en_i(dma_irq_en_i), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [31:0] model = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            logic [31:0] act;
            e = exp_q.pop_front();
            act = e.is_rd ? rd_data : {31'd0, irq_o};
            n_chk++;
            if (act !== e.val) begin
                n_err++;
                $display("FAIL %s: %s actual %h expected %h",
                         e.tag, e.is_rd ? "rd_data" : "irq_o", act, e.val);
            end
        end
    end

    // Driver: one cycle of stimulus with its expected results.
    task automatic step(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                        input logic [7:0] ra, input bit c, input bit ce,
                        input bit d, input bit de, input string tag);
        logic [31:0] setm, clrm, nxt;
        exp_t e;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        calc_done_i = c; calc_irq_en_i = ce; dma_done_i = d; dma_irq_en_i = de;
        setm = (we && wa == 8'h60) ? wd : 32'h0;
        if (c && ce) setm[0] = 1'b1;
        if (d && de) setm[8] = 1'b1;
        clrm = (we && wa == 8'h64) ? wd : 32'h0;
        nxt  = setm | (model & ~clrm);
        e.due = cyc + 1; e.is_rd = 1'b1; e.tag = tag;
        e.val = (ra == 8'h24) ? model : 32'h0;
        exp_q.push_back(e);
        e.is_rd = 1'b0; e.val = {31'd0, (nxt != 0)};
        exp_q.push_back(e);
        model = nxt;
        @(negedge clk);
        wr_en = 1'b0; calc_done_i = 1'b0; dma_done_i = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        exp_t e;
        rst_n = 1'b0;
        e.due = cyc + 1; e.is_rd = 1'b1; e.val = 32'h0; e.tag = tag;
        exp_q.push_back(e);
        e.is_rd = 1'b0;
        exp_q.push_back(e);
        model = 32'h0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1 reset state");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R1 idle after reset");
        step(1, 8'h60, 32'h0000_00A5, 8'h24, 0,0,0,0, "R2 raise A5");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R2 R4 read after raise");
        step(1, 8'h60, 32'h0F00_0000, 8'h24, 0,0,0,0, "R2 or-in upper");
        step(1, 8'h64, 32'h0000_0005, 8'h24, 0,0,0,0, "R3 ack low bits");
        step(1, 8'h24, 32'hFFFF_FFFF, 8'h24, 0,0,0,0, "R5 write status offset");
        step(1, 8'h40, 32'hFFFF_FFFF, 8'h60, 0,0,0,0, "R5 R6 unmapped write, read raise");
        step(0, 8'h00, 32'h0,        8'h64, 0,0,0,0, "R6 read ack offset");
        step(0, 8'h00, 32'h0,        8'h10, 0,0,0,0, "R6 read unmapped");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R3 R5 status unchanged");
        step(1, 8'h64, 32'h0F00_0000, 8'h24, 0,0,0,0, "R7 partial ack keeps line");
        step(1, 8'h64, 32'hFFFF_FFFF, 8'h24, 0,0,0,0, "R7 full ack drops line");
        step(0, 8'h00, 32'h0,        8'h24, 1,0,0,0, "R8 calc disabled");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,1,0, "R9 dma disabled");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R8 R9 nothing pending");
        step(0, 8'h00, 32'h0,        8'h24, 1,1,0,0, "R8 calc enabled");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R8 bit0 read");
        step(1, 8'h64, 32'h0000_0001, 8'h24, 0,0,0,0, "R7 clear bit0");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,1,1, "R9 dma enabled");
        step(1, 8'h64, 32'h0000_0100, 8'h24, 0,0,1,1, "R10 set beats ack");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R10 bit8 kept");
        step(1, 8'h64, 32'h0000_0101, 8'h24, 1,1,0,0, "R10 calc beats ack");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R10 bit0 kept");
        step(1, 8'h64, 32'hFFFF_FFFF, 8'h24, 0,0,0,0, "R7 clear all");
        step(1, 8'h60, 32'h8000_0000, 8'h24, 1,1,1,1, "R11 combined sets");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R11 combined read");
        do_reset("R1 reset mid-run");
        step(0, 8'h00, 32'h0,        8'h24, 0,0,0,0, "R1 cleared after reset");
        step(0, 8'h00, 32'h0,        8'h00, 0,0,0,0, "R1 drain");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule